// File: doc/BRIEF.md
# General Purpose Chip Select Cycle Sequencer

This block shapes the bus waveform of a single read or write to a static memory, a boot ROM or any simple peripheral that needs only a chip select and a read or write strobe. An address decoder elsewhere supplies the index of the matching bank, the direction of the transfer, and that bank's wait-state count and relaxed-timing option. The sequencer then plays out the cycle. It holds the address, drops the chip select of that one bank, opens a strobe window (output enable for reads, write enable for writes, with a data-valid strobe and a data drive enable), and flags the final bus clock with a done pulse.

The block runs on a clock at twice the bus rate. An internal phase bit marks the first and second half of each bus clock, so edges can be placed on half-cycle boundaries while every output comes straight from a flip-flop. A zero-wait access lasts two bus clocks. Each wait state adds one bus clock to the strobe window. Relaxed timing adds one bus clock of setup before the strobes open.

Top module: `gpcs_sequencer`

## Requirements
- R1: After reset, every `cs_n` bit, `oe_n` and `we_n` are high, `addr_hold`, `dval`, `drv_en` and `done` are low, and no cycle runs until a request arrives.
- R2: A held `start` is taken only while idle and only at the end of a bus clock, so a cycle always begins on a bus clock boundary. Pulses on `start` while a cycle runs are ignored. A request held through `done` starts the next cycle after exactly one idle bus clock (two half-cycles with `addr_hold` low).
- R3: `addr_hold` is high from the first half-cycle of the access through its last strobe half-cycle: 4 + 2*relax + 2*wait half-cycles in all, which is two bus clocks for a zero-wait access.
- R4: `bank` is a binary index, and index k drives `cs_n[k]`. The selected bit goes low from the second half of the first bus clock and stays low through the end of the strobe window (one half-cycle less than `addr_hold`). No other `cs_n` bit ever goes low.
- R5: The strobe window opens two half-cycles after `addr_hold` rises when `relax`=0, and four half-cycles after when `relax`=1.
- R6: The strobe window lasts 1 + `wait_st` bus clocks (2 + 2*`wait_st` half-cycles) and closes together with `addr_hold` and the chip select.
- R7: With `rd`=1, `oe_n` is low for the whole strobe window and `we_n` stays high. With `rd`=0, `we_n` is low for the window and `oe_n` stays high. The two are never low together.
- R8: `dval` and `drv_en` are high exactly during the strobe window, for reads and writes alike.
- R9: `done` is high for exactly one bus clock, the last bus clock of the strobe window.
- R10: `bank`, `rd`, `wait_st` and `relax` are sampled when the request is accepted. Changing them during the cycle has no effect on it.
- R11: A `bank` index of `BANKS` or more asserts no chip select. The timing of every other output is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Level request for a new access |
| bank | input | BANK_W (4) | Binary index of the decoded bank |
| rd | input | 1 | 1 = read, 0 = write |
| wait_st | input | WAIT_W (4) | Wait states of the bank, in bus clocks |
| relax | input | 1 | Adds one bus clock of setup before the strobes |
| addr_hold | output | 1 | Address latch/hold enable for the access |
| cs_n | output | BANKS (12) | Active-low chip selects, one per bank |
| oe_n | output | 1 | Active-low output enable (reads) |
| we_n | output | 1 | Active-low write enable (writes) |
| dval | output | 1 | Data-valid strobe |
| drv_en | output | 1 | Data bus drive enable for the data phase |
| done | output | 1 | High during the last bus clock of the access |

## Verification
The end of one access and the acceptance of the next request are the two functions that can land on the same edge. This happens when `start` is still high during the `done` bus clock. The bench provokes it by holding `start` across a whole access and counting the half-cycles during which `addr_hold` stays low before the next access begins. Exactly two are expected: the completion must win, and the new access must wait for the following bus clock boundary. A second test pulses `start` in the middle of a strobe window and releases it before the cycle ends. No further access may follow.

// File: rtl/gpcs_pkg.sv
package gpcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LEAD   = 2'd1,
    ST_SETUP  = 2'd2,
    ST_STROBE = 2'd3
  } gpcs_state_e;

endpackage

// File: rtl/gpcs_phase.sv
module gpcs_phase (
  input  logic clk2x,
  input  logic rst_n,
  output logic ph_q
);

  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // R2
  ph_toggle_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> (ph_q != $past(ph_q)));

endmodule

// File: rtl/gpcs_ctrl.sv
module gpcs_ctrl
  import gpcs_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int WAIT_W = 4
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              ph_q,
  input  logic              start,
  input  logic [BANK_W-1:0] bank_in,
  input  logic              rd_in,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic              relax_in,
  output gpcs_state_e       st_d,
  output logic [BANK_W-1:0] bank_d,
  output logic              rd_d,
  output logic              last_d
);

  gpcs_state_e       st_q;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [BANK_W-1:0] bank_q;
  logic              rd_q, rd_nx;
  logic              relax_q, relax_d;
  logic              accept;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bank_d  = bank_q;
    rd_nx   = rd_q;
    relax_d = relax_q;
    accept  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ph_q && start) begin
          accept  = 1'b1;
          st_d    = ST_LEAD;
          bank_d  = bank_in;
          rd_nx   = rd_in;
          cnt_d   = wait_in;
          relax_d = relax_in;
        end
      end
      ST_LEAD: begin
        if (ph_q) st_d = relax_q ? ST_SETUP : ST_STROBE;
      end
      ST_SETUP: begin
        if (ph_q) st_d = ST_STROBE;
      end
      ST_STROBE: begin
        if (ph_q) begin
          if (cnt_q == '0) st_d  = ST_IDLE;
          else             cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    rd_d   = rd_nx;
    last_d = (st_d == ST_STROBE) && (cnt_d == '0);
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      rd_q    <= 1'b0;
      relax_q <= 1'b0;
    end else begin
      st_q <= st_d;
      cnt_q <= cnt_d;
      if (accept) begin
        bank_q  <= bank_d;
        rd_q    <= rd_nx;
        relax_q <= relax_d;
      end
    end
  end

  // R2
  accept_boundary_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (st_q == ST_IDLE && !ph_q) |=> (st_q == ST_IDLE));

  // R2
  busy_ignore_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (st_q == ST_STROBE && cnt_q != '0) |=> (st_q == ST_STROBE));

  // R6
  strobe_whole_clock_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (st_q == ST_STROBE && !ph_q) |=> (st_q == ST_STROBE));

  // R10
  rd_hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(rd_q));

endmodule

// File: rtl/gpcs_drive.sv
module gpcs_drive
  import gpcs_pkg::*;
#(
  parameter int BANKS  = 12,
  parameter int BANK_W = 4
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              ph_q,
  input  gpcs_state_e       st_d,
  input  logic [BANK_W-1:0] bank_d,
  input  logic              rd_d,
  input  logic              last_d,
  output logic              addr_hold,
  output logic [BANKS-1:0]  cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dval,
  output logic              drv_en,
  output logic              done
);

  logic             ph_nx;
  logic             active, cs_on, strobe;
  logic [BANKS-1:0] cs_n_d;
  logic             addr_d, oe_n_d, we_n_d, dval_d, drv_d, done_d;

  always_comb begin
    ph_nx  = ~ph_q;
    active = (st_d != ST_IDLE);
    cs_on  = active && !((st_d == ST_LEAD) && !ph_nx);
    strobe = (st_d == ST_STROBE);
    addr_d = active;
    oe_n_d = !(strobe && rd_d);
    we_n_d = !(strobe && !rd_d);
    dval_d = strobe;
    drv_d  = strobe;
    done_d = last_d;
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_cs
    always_comb begin
      cs_n_d[k] = !(cs_on && (bank_d == BANK_W'(k)));
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      addr_hold <= 1'b0;
      cs_n      <= '1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dval      <= 1'b0;
      drv_en    <= 1'b0;
      done      <= 1'b0;
    end else begin
      addr_hold <= addr_d;
      cs_n      <= cs_n_d;
      oe_n      <= oe_n_d;
      we_n      <= we_n_d;
      dval      <= dval_d;
      drv_en    <= drv_d;
      done      <= done_d;
    end
  end

  // R4
  cs_single_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R7
  oe_we_excl_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R8
  dval_in_addr_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    dval |-> (addr_hold && drv_en));

  // R9
  done_in_strobe_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    done |-> dval);

  // R4
  cs_needs_addr_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (~cs_n != '0) |-> addr_hold);

endmodule

// File: rtl/gpcs_sequencer.sv
module gpcs_sequencer
  import gpcs_pkg::*;
#(
  parameter int BANKS  = 12,
  parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  parameter int WAIT_W = 4
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] bank,
  input  logic              rd,
  input  logic [WAIT_W-1:0] wait_st,
  input  logic              relax,
  output logic              addr_hold,
  output logic [BANKS-1:0]  cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dval,
  output logic              drv_en,
  output logic              done
);

  logic              ph_q;
  gpcs_state_e       st_d;
  logic [BANK_W-1:0] bank_d;
  logic              rd_d;
  logic              last_d;

  gpcs_phase u_phase (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .ph_q  (ph_q)
  );

  gpcs_ctrl #(
    .BANK_W (BANK_W),
    .WAIT_W (WAIT_W)
  ) u_ctrl (
    .clk2x    (clk2x),
    .rst_n    (rst_n),
    .ph_q     (ph_q),
    .start    (start),
    .bank_in  (bank),
    .rd_in    (rd),
    .wait_in  (wait_st),
    .relax_in (relax),
    .st_d     (st_d),
    .bank_d   (bank_d),
    .rd_d     (rd_d),
    .last_d   (last_d)
  );

  gpcs_drive #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) u_drive (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .ph_q      (ph_q),
    .st_d      (st_d),
    .bank_d    (bank_d),
    .rd_d      (rd_d),
    .last_d    (last_d),
    .addr_hold (addr_hold),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dval      (dval),
    .drv_en    (drv_en),
    .done      (done)
  );

  // R3
  addr_start_boundary_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(addr_hold) |-> (~cs_n == '0) && oe_n && we_n);

  // R5
  strobe_not_first_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(addr_hold) |=> !dval);

endmodule

// File: tb/sim_gpcs_sequencer.sv
module sim_gpcs_sequencer;

  localparam int BANKS  = 12;
  localparam int BANK_W = 4;
  localparam int WAIT_W = 4;

  // vector packing: {bank[3:0], rd, wait[3:0], relax}
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {4'd0,  1'b1, 4'd0,  1'b0},
    {4'd3,  1'b0, 4'd0,  1'b0},
    {4'd11, 1'b1, 4'd2,  1'b0},
    {4'd5,  1'b0, 4'd0,  1'b1},
    {4'd7,  1'b1, 4'd3,  1'b1},
    {4'd2,  1'b1, 4'd15, 1'b0},
    {4'd13, 1'b0, 4'd1,  1'b0}
  };

  logic              clk2x = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [BANK_W-1:0] bank  = '0;
  logic              rd    = 1'b0;
  logic [WAIT_W-1:0] wait_st = '0;
  logic              relax = 1'b0;
  logic              addr_hold;
  logic [BANKS-1:0]  cs_n;
  logic              oe_n, we_n, dval, drv_en, done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int n_len, n_cs, n_oth, n_dv, f_dv, n_oe, n_we, n_drv, n_done, f_done;

  always #5 clk2x = ~clk2x;

  gpcs_sequencer #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W),
    .WAIT_W (WAIT_W)
  ) u0 (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .start     (start),
    .bank      (bank),
    .rd        (rd),
    .wait_st   (wait_st),
    .relax     (relax),
    .addr_hold (addr_hold),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dval      (dval),
    .drv_en    (drv_en),
    .done      (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk2x) begin
    cyc++;
    if (cyc >= 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // Drives one access, scrambles the inputs once accepted (R10), and counts
  // half-cycles of each output at negedges.
  task automatic run_cycle(input logic [3:0] b, input logic r,
                           input logic [3:0] w, input logic rx);
    int h;
    @(negedge clk2x);
    bank = b; rd = r; wait_st = w; relax = rx; start = 1'b1;
    while (!addr_hold) @(negedge clk2x);
    start = 1'b0; bank = ~b; rd = ~r; wait_st = ~w; relax = ~rx;
    n_len = 0; n_cs = 0; n_oth = 0; n_dv = 0; f_dv = -1; n_oe = 0;
    n_we = 0; n_drv = 0; n_done = 0; f_done = -1;
    h = 0;
    while (addr_hold) begin
      for (int k = 0; k < BANKS; k++) begin
        if (!cs_n[k]) begin
          if (k == int'(b)) n_cs++;
          else              n_oth++;
        end
      end
      if (dval) begin
        if (f_dv < 0) f_dv = h;
        n_dv++;
      end
      if (!oe_n) n_oe++;
      if (!we_n) n_we++;
      if (drv_en) n_drv++;
      if (done) begin
        if (f_done < 0) f_done = h;
        n_done++;
      end
      h++;
      @(negedge clk2x);
    end
    n_len = h;
  endtask

  initial begin
    int quiet, gap;
    repeat (3) @(negedge clk2x);
    // R1 reset state
    chk("R1 cs_n", int'(cs_n), (1 << BANKS) - 1);
    chk("R1 strobes", {oe_n, we_n, addr_hold, dval, drv_en, done}, 6'b110000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk2x);
    chk("R1 idle", {addr_hold, dval, done}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] b;
      logic       r, rx;
      logic [3:0] w;
      int         t;
      {b, r, w, rx} = VEC[i];
      run_cycle(b, r, w, rx);
      t = 4 + 2 * int'(rx) + 2 * int'(w);
      chk("R3 addr_hold length", n_len, t);
      if (int'(b) < BANKS) chk("R4 cs length", n_cs, t - 1);
      else                 chk("R11 no cs for out-of-range bank", n_cs, 0);
      chk("R4 other cs", n_oth, 0);
      chk("R5 strobe start", f_dv, 2 + 2 * int'(rx));
      chk("R6 strobe length R10", n_dv, 2 + 2 * int'(w));
      chk("R7 oe_n", n_oe, r ? n_dv : 0);
      chk("R7 we_n", n_we, r ? 0 : n_dv);
      chk("R8 drv_en", n_drv, n_dv);
      chk("R9 done length", n_done, 2);
      chk("R9 done position", f_done, t - 2);
      repeat (3) @(negedge clk2x);
    end

    // R2: request pulsed mid-strobe is ignored
    @(negedge clk2x);
    bank = 4'd1; rd = 1'b1; wait_st = 4'd3; relax = 1'b0; start = 1'b1;
    while (!addr_hold) @(negedge clk2x);
    start = 1'b0;
    repeat (4) @(negedge clk2x);
    start = 1'b1;
    repeat (2) @(negedge clk2x);
    start = 1'b0;
    while (addr_hold) @(negedge clk2x);
    quiet = 0;
    for (int k = 0; k < 12; k++) begin
      if (addr_hold || !cs_n[1]) quiet++;
      @(negedge clk2x);
    end
    chk("R2 busy request ignored", quiet, 0);

    // R2: request held through done -> one idle bus clock between accesses
    bank = 4'd4; rd = 1'b0; wait_st = 4'd0; relax = 1'b0; start = 1'b1;
    while (!addr_hold) @(negedge clk2x);
    while (addr_hold) @(negedge clk2x);
    gap = 0;
    while (!addr_hold) begin
      gap++;
      @(negedge clk2x);
    end
    chk("R2 back-to-back gap", gap, 2);
    start = 1'b0;
    while (addr_hold) @(negedge clk2x);
    chk("R1 idle after run", {addr_hold, oe_n, we_n}, 3'b011);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule